// File: doc/BRIEF.md
# Interrupt Entry and Priority Controller

This block sits beside a small 8-bit processor core and decides when the core leaves its program to run an interrupt handler. It collects level requests from peripherals, requests from external pins (edge or level sensitive, with a per-pin choice of polarity), and a non-maskable software trap. A single global mask bit gates every maskable request. When several sources are pending at once, a fixed priority order picks one. The block then runs the entry sequence itself: it saves the core's context on a byte-wide stack port, sets the mask and hands the core the handler address read from a vector table.

A return request runs the same sequence backwards. It pops the saved context, gives it back to the core and takes the mask bit from the restored condition codes. Two wake outputs tell the power controller when a sleeping core must be woken. The light sleep state ends on any pending source. The deep sleep state ends only on pins and on peripherals that are configured as deep-wake capable.

Top module: `irq_entry_ctrl`

## Requirements
- R1: A maskable source is never taken while `mask` is 1. A source that was pending while masked is taken at the first instruction boundary after `mask` reads 0.
- R2: After reset, `mask` is 1, `busy` is 0, and no push, pop, load or restore strobe is asserted.
- R3: An entry starts only in a cycle where `insn_end` is 1 and the block is idle. `busy` rises in the next cycle.
- R4: An entry pushes five bytes in five consecutive cycles, one per cycle, in this order: PC low, PC high, X, A, CC. In the pushed CC byte, bit 3 holds the value `mask` had when the entry was taken, and the other bits are copied from `cc_in`.
- R5: In the cycle after the fifth push, `pc_load` is 1 for one cycle with `pc_value` equal to `vec_data`. `mask` reads 1 in that cycle and stays 1 afterwards until something changes it.
- R6: `iret` given while idle pops five bytes in five consecutive cycles, in this order: CC, A, X, PC high, PC low. `restore_valid` is then 1 for one cycle with the restored values. From the first pop onward, `mask` equals bit 3 of the popped CC byte.
- R7: Maskable sources are numbered as follows: pins 0..N_EXT-1 first, then peripherals. The lowest pending number wins. Source k reads its vector at `VEC_TOP - 2*(N_EXT+N_PER-k)` (0xFFF0 + 2k with the defaults).
- R8: `trap_exec` at an instruction boundary starts an entry whatever the value of `mask`. It wins over all maskable sources and uses vector address `VEC_TOP` (0xFFFC).
- R9: Each pin passes through a two-flop synchronizer. Its 2-bit sense code selects the behaviour: 00 falling edge, 01 rising edge, 10 both edges, 11 low level. A detected edge is latched until an entry for that same pin is taken. In level mode the request follows the synchronized pin and nothing is latched.
- R10: `wake_wait` is 1 whenever any maskable source is pending, whatever the value of `mask`. `wake_halt` is 1 only for pending pins and for pending peripherals whose bit in `PER_HALT` is set (peripheral 1 by default).
- R11: `mask_wr` loads `mask_wdata` into `mask` only while the block is idle. While an entry or a return is in progress, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_pin | input | N_EXT | Asynchronous external request pins |
| ext_mode | input | 2*N_EXT | Sense code per pin, 2 bits each |
| per_req | input | N_PER | Peripheral requests, flag already combined with enable |
| insn_end | input | 1 | Current instruction completes this cycle |
| trap_exec | input | 1 | Trap instruction executes (sampled with insn_end) |
| iret | input | 1 | Return-from-interrupt request |
| mask_wr | input | 1 | Software write strobe for the mask bit |
| mask_wdata | input | 1 | Value for the mask bit |
| pc_in | input | 16 | Core program counter to save |
| x_in | input | 8 | Core X register to save |
| a_in | input | 8 | Core accumulator to save |
| cc_in | input | 8 | Core condition codes to save |
| push_valid | output | 1 | Stack push strobe |
| push_data | output | 8 | Byte to push |
| pop_valid | output | 1 | Stack pop strobe; pop_data is sampled at this edge |
| pop_data | input | 8 | Byte on top of the stack |
| vec_addr | output | 16 | Vector table address of the winning source |
| vec_data | input | 16 | Vector table word at vec_addr |
| pc_load | output | 1 | Load the core PC with pc_value |
| pc_value | output | 16 | Handler address |
| restore_valid | output | 1 | Restored context is valid |
| ret_pc | output | 16 | Restored program counter |
| ret_x | output | 8 | Restored X register |
| ret_a | output | 8 | Restored accumulator |
| ret_cc | output | 8 | Restored condition codes |
| mask | output | 1 | Global interrupt mask bit |
| busy | output | 1 | Entry or return sequence in progress |
| wake_wait | output | 1 | Wake request for the light sleep state |
| wake_halt | output | 1 | Wake request for the deep sleep state |

## Verification
The bench first holds two peripheral requests pending under the mask, and then between instruction boundaries. This separates gating by the mask from gating by `insn_end`. When both are released, the lower-numbered peripheral must win. A trap raised while a maskable request is pending and the mask is set shows that the trap ignores the mask and outranks everything, and its return shows that the saved mask comes back as 1. Pins are driven with falling-edge and rising-edge patterns, where each pin also sees an edge it must ignore. Both pins stay latched until two successive entries clear them one at a time. A low-level phase on a pin shows that a level request disappears without any entry. A mask write during a return sequence shows that the write is ignored while the block is busy.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_PCL,
    ST_PUSH_PCH,
    ST_PUSH_X,
    ST_PUSH_A,
    ST_PUSH_CC,
    ST_VECTOR,
    ST_POP_CC,
    ST_POP_A,
    ST_POP_X,
    ST_POP_PCH,
    ST_POP_PCL,
    ST_RESUME
  } seq_t;

  localparam logic [1:0] SENSE_FALL = 2'd0;
  localparam logic [1:0] SENSE_RISE = 2'd1;
  localparam logic [1:0] SENSE_BOTH = 2'd2;
  localparam logic [1:0] SENSE_LOW  = 2'd3;

  // Edge qualifier for one synchronized pin sample pair.
  function automatic logic edge_match(input logic [1:0] sense,
                                      input logic now_v,
                                      input logic before_v);
    case (sense)
      SENSE_FALL: return before_v & ~now_v;
      SENSE_RISE: return ~before_v & now_v;
      SENSE_BOTH: return before_v ^ now_v;
      default:    return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irq_pin_sense.sv
module irq_pin_sense
  import irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic [1:0] sense,
  input  logic       clr,
  output logic       req,
  output logic       hit
);
  logic sync_a, sync_b, sync_prev, held;

  // Two-flop synchronizer plus one history flop; idles high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a    <= 1'b1;
      sync_b    <= 1'b1;
      sync_prev <= 1'b1;
    end else begin
      sync_a    <= pin;
      sync_b    <= sync_a;
      sync_prev <= sync_b;
    end
  end

  assign hit = edge_match(sense, sync_b, sync_prev);

  // A fresh edge wins over a clear in the same cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held <= 1'b0;
    else if (hit) held <= 1'b1;
    else if (clr) held <= 1'b0;
  end

  assign req = (sense == SENSE_LOW) ? ~sync_b : held;

  p_edge_kept_r9: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> held);

  p_clear_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !hit) |=> !held);

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter  int N  = 6,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  pend,
  output logic          any,
  output logic [IW-1:0] idx,
  output logic [N-1:0]  grant
);
  // Isolate the lowest set bit: lowest number = highest priority.
  function automatic logic [N-1:0] lowest_one(input logic [N-1:0] v);
    return v & (~v + 1'b1);
  endfunction

  assign any   = |pend;
  assign grant = lowest_one(pend);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) idx = IW'(i);
    end
  end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
  import irq_pkg::*;
#(
  parameter int               N_EXT    = 2,
  parameter int               N_PER    = 4,
  parameter int               MASK_BIT = 3,
  parameter logic [N_PER-1:0] PER_HALT = 4'b0010,
  parameter logic [15:0]      VEC_TOP  = 16'hFFFC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_EXT-1:0]   ext_pin,
  input  logic [2*N_EXT-1:0] ext_mode,
  input  logic [N_PER-1:0]   per_req,
  input  logic               insn_end,
  input  logic               trap_exec,
  input  logic               iret,
  input  logic               mask_wr,
  input  logic               mask_wdata,
  input  logic [15:0]        pc_in,
  input  logic [7:0]         x_in,
  input  logic [7:0]         a_in,
  input  logic [7:0]         cc_in,
  output logic               push_valid,
  output logic [7:0]         push_data,
  output logic               pop_valid,
  input  logic [7:0]         pop_data,
  output logic [15:0]        vec_addr,
  input  logic [15:0]        vec_data,
  output logic               pc_load,
  output logic [15:0]        pc_value,
  output logic               restore_valid,
  output logic [15:0]        ret_pc,
  output logic [7:0]         ret_x,
  output logic [7:0]         ret_a,
  output logic [7:0]         ret_cc,
  output logic               mask,
  output logic               busy,
  output logic               wake_wait,
  output logic               wake_halt
);
  localparam int NSRC = N_EXT + N_PER;
  localparam int IW   = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam logic [NSRC-1:0] HALT_OK = {PER_HALT, {N_EXT{1'b1}}};

  // Vector slot of maskable source k; the trap owns VEC_TOP.
  function automatic logic [15:0] slot_addr(input int k);
    return VEC_TOP - 16'(2 * (NSRC - k));
  endfunction

  seq_t            st;
  logic            mask_q;
  logic [15:0]     pc_q;
  logic [7:0]      x_q, a_q, cc_q, cc_ins;
  logic [15:0]     vaddr_q;
  logic [NSRC-1:0] pend, win_1h, clr_vec;
  logic [N_EXT-1:0] ext_hit;
  logic            any_pend;
  logic [IW-1:0]   win_idx;
  logic            idle, start_pop, take_trap, take_irq;

  // ---------------- request gathering ----------------
  for (genvar g = 0; g < N_EXT; g++) begin : g_pin
    irq_pin_sense u_sense (
      .clk   (clk),
      .rst_n (rst_n),
      .pin   (ext_pin[g]),
      .sense (ext_mode[2*g +: 2]),
      .clr   (clr_vec[g]),
      .req   (pend[g]),
      .hit   (ext_hit[g])
    );
  end
  assign pend[NSRC-1:N_EXT] = per_req;

  irq_pick #(.N(NSRC)) u_pick (
    .pend  (pend),
    .any   (any_pend),
    .idx   (win_idx),
    .grant (win_1h)
  );

  // ---------------- decision ----------------
  assign idle      = (st == ST_IDLE);
  assign start_pop = idle && iret;
  assign take_trap = idle && !iret && insn_end && trap_exec;
  assign take_irq  = idle && !iret && insn_end && !trap_exec && !mask_q && any_pend;
  assign clr_vec   = take_irq ? win_1h : '0;

  always_comb begin
    cc_ins           = cc_in;
    cc_ins[MASK_BIT] = mask_q;
  end

  // ---------------- sequencer ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      mask_q  <= 1'b1;
      pc_q    <= '0;
      x_q     <= '0;
      a_q     <= '0;
      cc_q    <= '0;
      vaddr_q <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start_pop) begin
            st <= ST_POP_CC;
          end else if (take_trap || take_irq) begin
            pc_q    <= pc_in;
            x_q     <= x_in;
            a_q     <= a_in;
            cc_q    <= cc_ins;
            vaddr_q <= take_trap ? VEC_TOP : slot_addr(int'(win_idx));
            st      <= ST_PUSH_PCL;
          end else if (mask_wr) begin
            mask_q <= mask_wdata;
          end
        end
        ST_PUSH_PCL: st <= ST_PUSH_PCH;
        ST_PUSH_PCH: st <= ST_PUSH_X;
        ST_PUSH_X:   st <= ST_PUSH_A;
        ST_PUSH_A:   st <= ST_PUSH_CC;
        ST_PUSH_CC: begin
          mask_q <= 1'b1;
          st     <= ST_VECTOR;
        end
        ST_VECTOR: st <= ST_IDLE;
        ST_POP_CC: begin
          cc_q   <= pop_data;
          mask_q <= pop_data[MASK_BIT];
          st     <= ST_POP_A;
        end
        ST_POP_A: begin
          a_q <= pop_data;
          st  <= ST_POP_X;
        end
        ST_POP_X: begin
          x_q <= pop_data;
          st  <= ST_POP_PCH;
        end
        ST_POP_PCH: begin
          pc_q[15:8] <= pop_data;
          st         <= ST_POP_PCL;
        end
        ST_POP_PCL: begin
          pc_q[7:0] <= pop_data;
          st        <= ST_RESUME;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // ---------------- outputs ----------------
  always_comb begin
    push_valid = 1'b1;
    case (st)
      ST_PUSH_PCL: push_data = pc_q[7:0];
      ST_PUSH_PCH: push_data = pc_q[15:8];
      ST_PUSH_X:   push_data = x_q;
      ST_PUSH_A:   push_data = a_q;
      ST_PUSH_CC:  push_data = cc_q;
      default: begin
        push_valid = 1'b0;
        push_data  = 8'h00;
      end
    endcase
  end

  assign pop_valid     = (st == ST_POP_CC) || (st == ST_POP_A) || (st == ST_POP_X) ||
                         (st == ST_POP_PCH) || (st == ST_POP_PCL);
  assign vec_addr      = vaddr_q;
  assign pc_load       = (st == ST_VECTOR);
  assign pc_value      = vec_data;
  assign restore_valid = (st == ST_RESUME);
  assign ret_pc        = pc_q;
  assign ret_x         = x_q;
  assign ret_a         = a_q;
  assign ret_cc        = cc_q;
  assign mask          = mask_q;
  assign busy          = !idle;
  assign wake_wait     = |pend;
  assign wake_halt     = |(pend & HALT_OK);

  // ---------------- assertions ----------------
  p_masked_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && mask_q && !trap_exec) |=> (st != ST_PUSH_PCL));

  p_boundary_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !insn_end) |=> (st != ST_PUSH_PCL));

  p_mask_at_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> mask);

  p_restore_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    restore_valid |-> (mask == ret_cc[MASK_BIT]));

  p_trap_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && insn_end && trap_exec && !iret) |=> (push_valid && vec_addr == VEC_TOP));

  p_one_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));

  p_halt_subset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wake_halt |-> wake_wait);

  p_busy_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mask_wr && st != ST_PUSH_CC && st != ST_POP_CC) |=> $stable(mask));

endmodule

// File: tb/test_irq_entry_ctrl.sv
`timescale 1ns/100ps
module test_irq_entry_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_pin = 2'b11;
  logic [3:0]  ext_mode = 4'b0000;
  logic [3:0]  per_req = 4'b0000;
  logic        insn_end = 1'b0, trap_exec = 1'b0, iret = 1'b0;
  logic        mask_wr = 1'b0, mask_wdata = 1'b0;
  logic [15:0] pc_in = 16'h0;
  logic [7:0]  x_in = 8'h0, a_in = 8'h0, cc_in = 8'h0;
  logic        push_valid, pop_valid, pc_load, restore_valid, mask, busy, wake_wait, wake_halt;
  logic [7:0]  push_data, ret_x, ret_a, ret_cc;
  logic [7:0]  pop_data = 8'h00;
  logic [15:0] vec_addr, vec_data, pc_value, ret_pc;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign vec_data = vec_addr ^ 16'h5A00;

  irq_entry_ctrl i_irq_entry_ctrl (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_mode(ext_mode), .per_req(per_req),
    .insn_end(insn_end), .trap_exec(trap_exec), .iret(iret), .mask_wr(mask_wr),
    .mask_wdata(mask_wdata), .pc_in(pc_in), .x_in(x_in), .a_in(a_in), .cc_in(cc_in),
    .push_valid(push_valid), .push_data(push_data), .pop_valid(pop_valid), .pop_data(pop_data),
    .vec_addr(vec_addr), .vec_data(vec_data), .pc_load(pc_load), .pc_value(pc_value),
    .restore_valid(restore_valid), .ret_pc(ret_pc), .ret_x(ret_x), .ret_a(ret_a),
    .ret_cc(ret_cc), .mask(mask), .busy(busy), .wake_wait(wake_wait), .wake_halt(wake_halt)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- stack memory behind the push/pop port ----------------
  logic [7:0] stk [$];
  always @(posedge clk) begin
    if (push_valid) stk.push_back(push_data);
    if (pop_valid && stk.size() > 0) void'(stk.pop_back());
    pop_data <= (stk.size() > 0) ? stk[stk.size()-1] : 8'h00;
  end

  // ---------------- behavioural reference model ----------------
  int          ph;
  bit          m_mask;
  bit          lat [2];
  int          pin_log [2];
  logic [7:0]  snap [5];
  logic [7:0]  mstk [$];
  logic [15:0] m_vaddr;
  logic [7:0]  r_cc, r_a, r_x, r_pch, r_pcl;

  function automatic bit m_edge(input logic [1:0] md, input bit now_v, input bit before_v);
    if (md == 2'd0) return before_v && !now_v;
    if (md == 2'd1) return !before_v && now_v;
    if (md == 2'd2) return before_v != now_v;
    return 1'b0;
  endfunction

  function automatic logic [5:0] m_pend();
    logic [5:0] v;
    for (int p = 0; p < 2; p++)
      v[p] = (ext_mode[2*p +: 2] == 2'd3) ? !pin_log[p][1] : lat[p];
    v[5:2] = per_req;
    return v;
  endfunction

  task automatic m_snap();
    logic [7:0] c;
    c = cc_in;
    c[3] = m_mask;
    snap[0] = pc_in[7:0];
    snap[1] = pc_in[15:8];
    snap[2] = x_in;
    snap[3] = a_in;
    snap[4] = c;
  endtask

  always @(posedge clk or negedge rst_n) begin
    logic [5:0] pv;
    bit hitv [2];
    int win;
    if (!rst_n) begin
      ph = 0; m_mask = 1'b1;
      lat[0] = 1'b0; lat[1] = 1'b0;
      pin_log[0] = 7; pin_log[1] = 7;
      mstk.delete();
    end else begin
      pv = m_pend();
      win = -1;
      for (int p = 0; p < 2; p++)
        hitv[p] = m_edge(ext_mode[2*p +: 2], pin_log[p][1], pin_log[p][2]);
      case (ph)
        0: begin
          if (iret) ph = 7;
          else if (insn_end && trap_exec) begin
            m_snap(); m_vaddr = 16'hFFFC; ph = 1;
          end else if (insn_end && !m_mask && pv != 0) begin
            for (int k = 5; k >= 0; k--) if (pv[k]) win = k;
            m_vaddr = 16'hFFFC - 16'(2 * (6 - win));
            m_snap(); ph = 1;
          end else if (mask_wr) m_mask = mask_wdata;
        end
        1, 2, 3, 4: begin mstk.push_back(snap[ph-1]); ph++; end
        5:  begin mstk.push_back(snap[4]); m_mask = 1'b1; ph = 6; end
        6:  ph = 0;
        7:  begin r_cc  = mstk.pop_back(); m_mask = r_cc[3]; ph = 8; end
        8:  begin r_a   = mstk.pop_back(); ph = 9;  end
        9:  begin r_x   = mstk.pop_back(); ph = 10; end
        10: begin r_pch = mstk.pop_back(); ph = 11; end
        11: begin r_pcl = mstk.pop_back(); ph = 12; end
        default: ph = 0;
      endcase
      for (int p = 0; p < 2; p++) begin
        if (hitv[p]) lat[p] = 1'b1;
        else if (win == p) lat[p] = 1'b0;
      end
      for (int p = 0; p < 2; p++)
        pin_log[p] = ((pin_log[p] << 1) | int'(ext_pin[p])) & 7;
    end
  end

  // Compare against the model on every clock, away from the rising edge.
  always @(negedge clk) begin
    logic [5:0] pv;
    if (rst_n && !done) begin
      pv = m_pend();
      chk(mask == m_mask, "R1 mask", 32'(mask), 32'(m_mask));
      chk(busy == (ph != 0), "R3 busy", 32'(busy), 32'(ph != 0));
      chk(push_valid == (ph >= 1 && ph <= 5), "R4 push_valid", 32'(push_valid), 32'(ph));
      if (ph >= 1 && ph <= 5) chk(push_data == snap[ph-1], "R4 push_data", 32'(push_data), 32'(snap[ph-1]));
      chk(pc_load == (ph == 6), "R5 pc_load", 32'(pc_load), 32'(ph == 6));
      if (ph == 6) begin
        chk(vec_addr == m_vaddr, "R7 vec_addr", 32'(vec_addr), 32'(m_vaddr));
        chk(pc_value == (m_vaddr ^ 16'h5A00), "R5 pc_value", 32'(pc_value), 32'(m_vaddr ^ 16'h5A00));
      end
      chk(pop_valid == (ph >= 7 && ph <= 11), "R6 pop_valid", 32'(pop_valid), 32'(ph));
      chk(restore_valid == (ph == 12), "R6 restore_valid", 32'(restore_valid), 32'(ph == 12));
      if (ph == 12) begin
        chk(ret_cc == r_cc, "R6 ret_cc", 32'(ret_cc), 32'(r_cc));
        chk(ret_pc == {r_pch, r_pcl}, "R6 ret_pc", 32'(ret_pc), 32'({r_pch, r_pcl}));
        chk(ret_x == r_x && ret_a == r_a, "R6 ret_xa", 32'({ret_x, ret_a}), 32'({r_x, r_a}));
      end
      chk(wake_wait == (pv != 0), "R10 wake_wait", 32'(wake_wait), 32'(pv != 0));
      chk(wake_halt == ((pv & 6'b001011) != 0), "R10 wake_halt", 32'(wake_halt), 32'(pv));
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic finish_run();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(mask == 1'b1, "R2 reset mask", 32'(mask), 1);
    chk(!busy && !push_valid && !pop_valid && !pc_load && !restore_valid, "R2 reset strobes", 32'(busy), 0);

    // Peripherals 0 and 1 pending while masked.
    #1 per_req = 4'b0011; insn_end = 1'b1;
    pc_in = 16'h1234; x_in = 8'h56; a_in = 8'h78; cc_in = 8'hE9;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R1 masked no entry", 32'(busy), 0);
    chk(wake_halt == 1'b1, "R10 halt-capable peripheral", 32'(wake_halt), 1);
    #1 per_req = 4'b0001;
    @(negedge clk);
    chk(wake_halt == 1'b0, "R10 non halt peripheral", 32'(wake_halt), 0);
    chk(wake_wait == 1'b1, "R10 wait wake", 32'(wake_wait), 1);

    // Unmask between instruction boundaries.
    #1 per_req = 4'b0011; insn_end = 1'b0; mask_wr = 1'b1; mask_wdata = 1'b0;
    @(negedge clk);
    chk(mask == 1'b0, "R11 idle write", 32'(mask), 0);
    #1 mask_wr = 1'b0;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R3 no boundary", 32'(busy), 0);
    #1 insn_end = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R1 taken once unmasked", 32'(busy), 1);
    #1 insn_end = 1'b0;
    repeat (5) @(negedge clk);
    chk(pc_load == 1'b1, "R5 load", 32'(pc_load), 1);
    chk(vec_addr == 16'hFFF4, "R7 peripheral 0 wins", 32'(vec_addr), 32'h FFF4);
    chk(mask == 1'b1, "R5 mask set", 32'(mask), 1);
    chk(stk.size() == 5, "R4 depth", 32'(stk.size()), 5);
    if (stk.size() == 5) begin
      chk(stk[0] == 8'h34 && stk[1] == 8'h12, "R4 pc bytes", 32'({stk[1], stk[0]}), 32'h1234);
      chk(stk[2] == 8'h56 && stk[3] == 8'h78, "R4 x a bytes", 32'({stk[2], stk[3]}), 32'h5678);
      chk(stk[4] == 8'hE1, "R4 cc with mask", 32'(stk[4]), 32'hE1);
    end
    #1 per_req = 4'b0000;
    @(negedge clk);

    // Return, with a mask write attempted mid-sequence.
    #1 iret = 1'b1;
    @(negedge clk);
    #1 iret = 1'b0;
    @(negedge clk);
    #1 mask_wr = 1'b1; mask_wdata = 1'b1;
    @(negedge clk);
    chk(mask == 1'b0, "R11 busy write ignored", 32'(mask), 0);
    #1 mask_wr = 1'b0;
    repeat (3) @(negedge clk);
    chk(restore_valid == 1'b1, "R6 restore", 32'(restore_valid), 1);
    chk(ret_pc == 16'h1234 && ret_cc == 8'hE1, "R6 values", 32'({ret_pc, ret_cc}), 32'h1234E1);
    chk(mask == 1'b0, "R6 mask cleared", 32'(mask), 0);
    @(negedge clk);

    // Trap under mask, beating a pending peripheral.
    #1 mask_wr = 1'b1; mask_wdata = 1'b1;
    @(negedge clk);
    #1 mask_wr = 1'b0; trap_exec = 1'b1; insn_end = 1'b1; per_req = 4'b0100;
    @(negedge clk);
    chk(busy == 1'b1, "R8 trap taken masked", 32'(busy), 1);
    #1 trap_exec = 1'b0; insn_end = 1'b0;
    repeat (5) @(negedge clk);
    chk(vec_addr == 16'hFFFC, "R8 trap vector", 32'(vec_addr), 32'hFFFC);
    #1 per_req = 4'b0000;
    @(negedge clk);
    #1 iret = 1'b1;
    @(negedge clk);
    #1 iret = 1'b0;
    repeat (5) @(negedge clk);
    chk(ret_cc == 8'hE9 && mask == 1'b1, "R8 mask kept after trap", 32'({ret_cc, 7'd0, mask}), 32'hE901);
    @(negedge clk);

    // Pins: 0 falling, 1 rising. Each sees an edge it must ignore.
    #1 ext_mode = 4'b0100; ext_pin = 2'b00;
    repeat (4) @(negedge clk);
    chk(wake_wait == 1'b1 && wake_halt == 1'b1, "R9 falling latched", 32'({wake_wait, wake_halt}), 3);
    #1 ext_pin = 2'b11;
    repeat (4) @(negedge clk);
    chk(wake_wait == 1'b1, "R9 latch held", 32'(wake_wait), 1);
    #1 mask_wr = 1'b1; mask_wdata = 1'b0;
    @(negedge clk);
    #1 mask_wr = 1'b0; insn_end = 1'b1;
    @(negedge clk);
    #1 insn_end = 1'b0;
    repeat (5) @(negedge clk);
    chk(vec_addr == 16'hFFF0, "R7 pin 0 first", 32'(vec_addr), 32'hFFF0);
    chk(wake_wait == 1'b1, "R9 other pin kept", 32'(wake_wait), 1);
    @(negedge clk);
    #1 iret = 1'b1;
    @(negedge clk);
    #1 iret = 1'b0;
    repeat (6) @(negedge clk);
    #1 insn_end = 1'b1;
    @(negedge clk);
    #1 insn_end = 1'b0;
    repeat (5) @(negedge clk);
    chk(vec_addr == 16'hFFF2, "R9 rising latch taken", 32'(vec_addr), 32'hFFF2);
    chk(wake_wait == 1'b0, "R9 both cleared", 32'(wake_wait), 0);
    @(negedge clk);

    // Level mode on pin 0.
    #1 ext_mode = 4'b0111; ext_pin = 2'b10;
    repeat (3) @(negedge clk);
    chk(wake_wait == 1'b1, "R9 low level", 32'(wake_wait), 1);
    #1 ext_pin = 2'b11;
    repeat (3) @(negedge clk);
    chk(wake_wait == 1'b0, "R9 level not latched", 32'(wake_wait), 0);

    finish_run();
  end

endmodule